// File: doc/BRIEF.md
# Software Standby Power Controller

This block decides when a small microcontroller may drop into a deep standby state and how it comes back. A sleep strobe from the CPU moves the block into standby, but only when the control bits allow it. The block then stops the oscillator, gates the CPU and peripheral clocks, releases the external bus and holds a fixed group of peripherals in reset. Registers and RAM are not touched.

Four events end standby: an NMI edge of a selectable polarity, a qualified IRQ line, a low level on the reset pin, or a low level on the hardware-standby pin. An interrupt wake restarts the oscillator and counts a programmable settling time before clocks come back and an interrupt exception is requested. A reset-pin wake gives clocks back at once and requests a reset exception when the pin is released. The hardware-standby pin overrides everything else.

Top module: `sstby_pwr_ctrl`

## Requirements
- R1: Standby is entered on a clock edge with `sleep_i`=1 in the active mode only when `stby_sel_i`=1, `lowspd_sel_i`=0 and `wdt_clksel_i`=0; any other combination leaves the mode active.
- R2: In standby and hardware standby, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are 0; during settling only `osc_en_o` is 1; in the active mode all three are 1.
- R3: `per_rst_o` (one bit each for serial, A/D, motor PWM and CAN) is all ones in every mode except active, where it is all zeros.
- R4: `bus_oe_o` is 1 only in the active mode, so the address bus and bus-control pins float in every other mode.
- R5: In standby, an NMI falling edge wakes the block when `nmi_rise_sel_i`=0 and a rising edge wakes it when `nmi_rise_sel_i`=1; the opposite edge is ignored.
- R6: An interrupt wake enters settling; settling lasts N clock cycles, where codes 0 to 5 of `settle_code_i` give N = 8192 << code and codes 6 and 7 give N = 16; the block then returns to active and pulses `int_exc_o` for one cycle in the first active cycle.
- R7: IRQ line k wakes standby only if `irq_i[k]`, `irq_en_i[k]` are 1, `irq_dtc_i[k]` is 0 and `irq_mask_i` is 0; otherwise the block stays in standby.
- R8: A low `res_pin_n_i` in standby or settling returns the block to active on the next edge with no settling wait and no `int_exc_o`; the cycle after `res_pin_n_i` rises, `rst_exc_o` is 1 for one cycle.
- R9: A low `hwstby_pin_n_i` moves the block to hardware standby on the next edge from any mode; when the pin is high again the block returns to active on the next edge.
- R10: A sleep strobe in any mode other than active has no effect on the mode.
- R11: `mode_o` reports 0 for active, 1 for standby, 2 for settling and 3 for hardware standby; after `por_n` the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of the block, active low |
| sleep_i | input | 1 | Sleep instruction strobe |
| stby_sel_i | input | 1 | Standby select control bit |
| lowspd_sel_i | input | 1 | Low-speed select control bit |
| wdt_clksel_i | input | 1 | Watchdog clock select control bit |
| settle_code_i | input | 3 | Oscillator settling time code |
| nmi_i | input | 1 | NMI pin level |
| nmi_rise_sel_i | input | 1 | NMI edge: 0 falling, 1 rising |
| irq_i | input | IRQ_W | IRQ request levels |
| irq_en_i | input | IRQ_W | IRQ enable bits |
| irq_mask_i | input | 1 | CPU interrupt mask |
| irq_dtc_i | input | IRQ_W | IRQ routed to DTC activation |
| res_pin_n_i | input | 1 | Reset pin, active low |
| hwstby_pin_n_i | input | 1 | Hardware-standby pin, active low |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| bus_oe_o | output | 1 | Address bus and bus-control output enable |
| per_rst_o | output | RST_W | Reset for the peripherals not retained in standby |
| int_exc_o | output | 1 | Interrupt exception request pulse |
| rst_exc_o | output | 1 | Reset exception request pulse |
| mode_o | output | 2 | Current mode |

## Verification
The assertions assume the settling code, the edge select and the IRQ qualifiers are stable while a wake is being judged, and that the NMI pin has been stable for at least two cycles after reset before a wake can matter. The stimulus changes control inputs only on falling clock edges and only while the block is active or idle in standby, and it holds the hardware-standby and reset pins high except in the tests aimed at them. Settling is only exercised with short codes and code 0, so the long counts above 8192 are reached by the mapping requirement alone.

// File: rtl/sstby_pwr_ctrl.sv
module sstby_pwr_ctrl #(
  parameter int RST_W     = 4,
  parameter int IRQ_W     = 6,
  parameter int BASE_LOG  = 13,
  parameter int SHORT_CNT = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sleep_i,
  input  logic             stby_sel_i,
  input  logic             lowspd_sel_i,
  input  logic             wdt_clksel_i,
  input  logic [2:0]       settle_code_i,
  input  logic             nmi_i,
  input  logic             nmi_rise_sel_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             irq_mask_i,
  input  logic [IRQ_W-1:0] irq_dtc_i,
  input  logic             res_pin_n_i,
  input  logic             hwstby_pin_n_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             bus_oe_o,
  output logic [RST_W-1:0] per_rst_o,
  output logic             int_exc_o,
  output logic             rst_exc_o,
  output logic [1:0]       mode_o
);
  localparam int CNT_W = BASE_LOG + 6;
  localparam logic [1:0] M_ACT = 2'd0, M_STBY = 2'd1, M_SETL = 2'd2, M_HW = 2'd3;

  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       code_q;
  logic             nmi_q, res_q;

  function automatic logic [CNT_W-1:0] settle_len(input logic [2:0] c);
    if (c < 3'd6) return CNT_W'(1) << (BASE_LOG + int'(c));
    return CNT_W'(SHORT_CNT);
  endfunction

  wire enter_ok = stby_sel_i & ~lowspd_sel_i & ~wdt_clksel_i;
  wire nmi_edge = nmi_rise_sel_i ? (nmi_i & ~nmi_q) : (~nmi_i & nmi_q);
  wire irq_wake = (|(irq_i & irq_en_i & ~irq_dtc_i)) & ~irq_mask_i;
  wire settled  = (cnt == settle_len(code_q) - CNT_W'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode      <= M_ACT;
      cnt       <= '0;
      code_q    <= '0;
      nmi_q     <= 1'b1;
      res_q     <= 1'b1;
      int_exc_o <= 1'b0;
      rst_exc_o <= 1'b0;
    end else begin
      nmi_q     <= nmi_i;
      res_q     <= res_pin_n_i;
      int_exc_o <= 1'b0;
      rst_exc_o <= res_pin_n_i & ~res_q & (mode != M_HW);
      if (!hwstby_pin_n_i) begin
        mode <= M_HW;
      end else begin
        case (mode)
          M_ACT: if (sleep_i && enter_ok) begin
            mode <= M_STBY;
            cnt  <= '0;
          end
          M_STBY: if (!res_pin_n_i) begin
            mode <= M_ACT;
          end else if (nmi_edge || irq_wake) begin
            mode   <= M_SETL;
            cnt    <= '0;
            code_q <= settle_code_i;
          end
          M_SETL: if (!res_pin_n_i) begin
            mode <= M_ACT;
          end else if (settled) begin
            mode      <= M_ACT;
            int_exc_o <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
          default: mode <= M_ACT;
        endcase
      end
    end
  end

  assign mode_o       = mode;
  assign osc_en_o     = (mode == M_ACT) || (mode == M_SETL);
  assign cpu_clk_en_o = (mode == M_ACT);
  assign per_clk_en_o = (mode == M_ACT);
  assign bus_oe_o     = (mode == M_ACT);
  assign per_rst_o    = {RST_W{mode != M_ACT}};
endmodule

// File: rtl/sstby_pwr_ctrl_chk.sv
module sstby_pwr_ctrl_chk #(
  parameter int RST_W = 4,
  parameter int IRQ_W = 6
) (
  input logic             clk,
  input logic             por_n,
  input logic             sleep_i,
  input logic             stby_sel_i,
  input logic             lowspd_sel_i,
  input logic             wdt_clksel_i,
  input logic             nmi_i,
  input logic             nmi_rise_sel_i,
  input logic [IRQ_W-1:0] irq_i,
  input logic [IRQ_W-1:0] irq_en_i,
  input logic             irq_mask_i,
  input logic [IRQ_W-1:0] irq_dtc_i,
  input logic             res_pin_n_i,
  input logic             hwstby_pin_n_i,
  input logic             osc_en_o,
  input logic             cpu_clk_en_o,
  input logic             bus_oe_o,
  input logic [RST_W-1:0] per_rst_o,
  input logic             int_exc_o,
  input logic [1:0]       mode_o
);
  AST_ENTRY_COND: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == 2'd1 && $past(mode_o) == 2'd0) |->
      $past(sleep_i && stby_sel_i && !lowspd_sel_i && !wdt_clksel_i)); // R1
  AST_OSC_STOPPED: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == 2'd1 || mode_o == 2'd3) |-> (!osc_en_o && !cpu_clk_en_o)); // R2
  AST_PER_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o != 2'd0) |-> (&per_rst_o)); // R3
  AST_BUS_FLOAT: assert property (@(posedge clk) disable iff (!por_n)
    bus_oe_o |-> (mode_o == 2'd0)); // R4
  AST_SETTLE_EXC: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == 2'd0 && $past(mode_o) == 2'd2 && $past(res_pin_n_i) && $past(hwstby_pin_n_i))
      |-> int_exc_o); // R6
  AST_WAKE_QUAL: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == 2'd2 && $past(mode_o) == 2'd1) |->
      (($past(nmi_rise_sel_i) ? ($past(nmi_i) && !$past(nmi_i, 2)) : (!$past(nmi_i) && $past(nmi_i, 2)))
       || ((|$past(irq_i & irq_en_i & ~irq_dtc_i)) && !$past(irq_mask_i)))); // R7
  AST_RESET_FAST: assert property (@(posedge clk) disable iff (!por_n)
    ($past(!res_pin_n_i && hwstby_pin_n_i) && ($past(mode_o) == 2'd1 || $past(mode_o) == 2'd2))
      |-> (mode_o == 2'd0 && !int_exc_o)); // R8
  AST_HW_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    $past(!hwstby_pin_n_i) |-> (mode_o == 2'd3)); // R9
endmodule

bind sstby_pwr_ctrl sstby_pwr_ctrl_chk #(.RST_W(RST_W), .IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .por_n(por_n), .sleep_i(sleep_i), .stby_sel_i(stby_sel_i),
  .lowspd_sel_i(lowspd_sel_i), .wdt_clksel_i(wdt_clksel_i), .nmi_i(nmi_i),
  .nmi_rise_sel_i(nmi_rise_sel_i), .irq_i(irq_i), .irq_en_i(irq_en_i),
  .irq_mask_i(irq_mask_i), .irq_dtc_i(irq_dtc_i), .res_pin_n_i(res_pin_n_i),
  .hwstby_pin_n_i(hwstby_pin_n_i), .osc_en_o(osc_en_o), .cpu_clk_en_o(cpu_clk_en_o),
  .bus_oe_o(bus_oe_o), .per_rst_o(per_rst_o), .int_exc_o(int_exc_o), .mode_o(mode_o)
);

// File: tb/sstby_pwr_ctrl_tb.sv
module sstby_pwr_ctrl_tb_top;
  logic clk = 1'b0, por_n = 1'b0;
  logic sleep_i = 0, stby_sel_i = 0, lowspd_sel_i = 0, wdt_clksel_i = 0;
  logic [2:0] settle_code_i = 3'd6;
  logic nmi_i = 1, nmi_rise_sel_i = 0, irq_mask_i = 0;
  logic [5:0] irq_i = '0, irq_en_i = '0, irq_dtc_i = '0;
  logic res_pin_n_i = 1, hwstby_pin_n_i = 1;
  logic osc_en_o, cpu_clk_en_o, per_clk_en_o, bus_oe_o, int_exc_o, rst_exc_o;
  logic [3:0] per_rst_o;
  logic [1:0] mode_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sstby_pwr_ctrl dut_i (.*);

  // {stby_sel, lowspd_sel, wdt_clksel, expect_standby}
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0010, 4'b0100, 4'b0110,
                                     4'b1001, 4'b1010, 4'b1100, 4'b1110};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter();
    stby_sel_i = 1; lowspd_sel_i = 0; wdt_clksel_i = 0; sleep_i = 1;
    tick(1);
    sleep_i = 0;
    chk("R1 enter", mode_o, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    tick(3);
    por_n = 1;
    tick(1);
    chk("R11 reset mode", mode_o, 0);
    chk("R2 reset clocks", {osc_en_o, cpu_clk_en_o, per_clk_en_o}, 7);
    chk("R3 reset per_rst", per_rst_o, 0);
    chk("R4 reset bus_oe", bus_oe_o, 1);

    for (int i = 0; i < 8; i++) begin
      {stby_sel_i, lowspd_sel_i, wdt_clksel_i} = VEC[i][3:1];
      sleep_i = 1;
      tick(1);
      sleep_i = 0;
      chk("R1 entry table", mode_o, VEC[i][0] ? 1 : 0);
      if (VEC[i][0]) begin
        chk("R2 standby clocks", {osc_en_o, cpu_clk_en_o, per_clk_en_o}, 0);
        chk("R3 standby per_rst", per_rst_o, 15);
        chk("R4 standby bus_oe", bus_oe_o, 0);
        res_pin_n_i = 0;
        tick(1);
        chk("R8 reset wake", mode_o, 0);
        chk("R8 reset clocks", {osc_en_o, cpu_clk_en_o}, 3);
        res_pin_n_i = 1;
        tick(1);
        chk("R8 reset exception", rst_exc_o, 1);
        tick(1);
        chk("R8 reset exception pulse", rst_exc_o, 0);
      end
    end

    // NMI falling edge, short settle
    enter();
    nmi_i = 0;
    tick(1);
    chk("R5 falling wake", mode_o, 2);
    chk("R2 settle clocks", {osc_en_o, cpu_clk_en_o, per_clk_en_o}, 4);
    tick(15);
    chk("R6 still settling", mode_o, 2);
    tick(1);
    chk("R6 settle done", mode_o, 0);
    chk("R6 int exception", int_exc_o, 1);
    tick(1);
    chk("R6 int exception pulse", int_exc_o, 0);
    nmi_i = 1;

    // NMI rising select ignores falling edge
    nmi_rise_sel_i = 1;
    enter();
    nmi_i = 0;
    tick(2);
    chk("R5 falling ignored", mode_o, 1);
    nmi_i = 1;
    tick(1);
    chk("R5 rising wake", mode_o, 2);
    tick(16);
    chk("R6 rising settle done", mode_o, 0);
    nmi_rise_sel_i = 0;

    // IRQ qualification
    enter();
    irq_i = 6'b000100;
    tick(2);
    chk("R7 disabled irq", mode_o, 1);
    irq_en_i = 6'b000100; irq_mask_i = 1;
    tick(2);
    chk("R7 masked irq", mode_o, 1);
    irq_mask_i = 0; irq_dtc_i = 6'b000100;
    tick(2);
    chk("R7 dtc irq", mode_o, 1);
    irq_dtc_i = '0;
    tick(1);
    chk("R7 qualified irq", mode_o, 2);
    irq_i = '0;
    tick(16);
    chk("R7 irq settle done", mode_o, 0);

    // Code 7 short count, sleep during settle ignored
    settle_code_i = 3'd7;
    enter();
    nmi_i = 0;
    tick(1);
    sleep_i = 1;
    tick(1);
    sleep_i = 0;
    chk("R10 sleep while settling", mode_o, 2);
    tick(14);
    chk("R6 code7 still settling", mode_o, 2);
    tick(1);
    chk("R6 code7 done", mode_o, 0);
    nmi_i = 1;

    // Code 0 long count
    settle_code_i = 3'd0;
    enter();
    nmi_i = 0;
    tick(1);
    tick(8191);
    chk("R6 code0 still settling", mode_o, 2);
    tick(1);
    chk("R6 code0 done", mode_o, 0);
    chk("R6 code0 exception", int_exc_o, 1);
    nmi_i = 1;

    // Reset pin during settling
    enter();
    nmi_i = 0;
    tick(1);
    tick(10);
    res_pin_n_i = 0;
    tick(1);
    chk("R8 reset during settle", mode_o, 0);
    chk("R8 no int exception", int_exc_o, 0);
    res_pin_n_i = 1;
    tick(1);
    chk("R8 reset release", rst_exc_o, 1);
    nmi_i = 1;
    settle_code_i = 3'd6;

    // Hardware standby
    enter();
    hwstby_pin_n_i = 0;
    tick(1);
    chk("R9 hw standby entry", mode_o, 3);
    chk("R2 hw clocks", {osc_en_o, cpu_clk_en_o}, 0);
    chk("R3 hw per_rst", per_rst_o, 15);
    chk("R4 hw bus_oe", bus_oe_o, 0);
    sleep_i = 1;
    tick(1);
    sleep_i = 0;
    chk("R10 sleep in hw standby", mode_o, 3);
    hwstby_pin_n_i = 1;
    tick(1);
    chk("R9 hw standby exit", mode_o, 0);
    hwstby_pin_n_i = 0;
    tick(1);
    chk("R9 hw from active", mode_o, 3);
    hwstby_pin_n_i = 1;
    tick(1);
    chk("R9 hw exit again", mode_o, 0);

    // Sleep in standby is a no-op
    enter();
    sleep_i = 1; stby_sel_i = 0;
    tick(2);
    sleep_i = 0;
    chk("R10 sleep in standby", mode_o, 1);
    res_pin_n_i = 0;
    tick(1);
    res_pin_n_i = 1;
    tick(1);
    chk("R8 final wake", mode_o, 0);

    done = 1;
    finish_run();
  end
endmodule